// File: doc/BRIEF.md
# Channel List Scan Sequencer

The sequencer holds a programmable list of up to 32 acquisition entries and walks it once for every scan-start pulse. Each entry names an input channel, single-ended or differential wiring, a gain code, a flag that doubles the settling wait, a flag asking for a timestamp to be inserted, and a flag saying that another entry follows. For each entry the block drives the input multiplexer and gain selection, waits for the signal to settle, strobes the converter, waits for the converter to report completion, and then emits a sample strobe tagged with the entry index and channel number.

Two pacing modes exist. In scan-clock mode the wait before each conversion is derived from the gain code and the clock frequency parameter, so each channel gets the longest settling the gain needs. In conversion-clock mode the scan pulse only starts the pass and every conversion waits for a pulse on a separate conversion clock. Entries that cannot be converted are skipped and flagged, and scan pulses that arrive mid-pass are dropped and flagged.

Top module: `scan_seq`

## Requirements
- R1: A list write with `lst_we_i` high stores `lst_data_i` at entry `lst_addr_i`. Entry fields: bit 31 another entry follows, bit 20 timestamp request, bit 19 double settling, bit 15 differential, bits 11:8 gain code, bits 7:0 channel number.
- R2: After reset `busy_o`, `conv_o`, `ts_req_o`, `smp_valid_o`, `ovr_o` and `err_o` are low, and no strobe is ever raised while `busy_o` is low.
- R3: A scan pulse while idle starts a pass at entry 0; `busy_o` is high from the next cycle until the cycle holding the pass's last action (last sample strobe, or the decision cycle of a trailing skipped entry).
- R4: In scan-clock mode `conv_o` is a one-cycle pulse raised N+2 cycles after the scan-pulse cycle for entry 0, or N+2 cycles after the previous entry's sample strobe, where N = CLK_HZ/1e6 times 10, 15, 25 or 50 for gain codes 0, 1, 2, 3.
- R5: With bit 19 set, the N of R4 is doubled.
- R6: While an entry is converted `gain_o` equals its gain code and `diff_o` its bit 15; channel n selects `mux_pos_o` = n; `mux_neg_o` is 31 (analog ground) in single-ended mode, n+12 for a differential channel 0 to 11, and 25 for differential channel 24 (thermocouple compensation input 24).
- R7: In conversion-clock mode `conv_o` is raised in the cycle after the first `conv_pulse_i` that comes at least one cycle after the entry is taken up (scan-pulse cycle + 1, or previous sample strobe + 1); earlier conversion pulses, and all conversion pulses in scan-clock mode, have no effect.
- R8: `adc_done_i` is honoured only while a conversion is outstanding; the cycle after it, `smp_valid_o` pulses for one cycle with `smp_idx_o` and `smp_chan_o` of that entry.
- R9: For an entry with bit 20 set, `ts_req_o` pulses for one cycle directly after `adc_done_i` and `smp_valid_o` follows in the next cycle.
- R10: After a sample strobe the pass continues with the next entry in the following cycle if bit 31 is set and the entry is not entry 31; otherwise it ends and `busy_o` drops.
- R11: A scan pulse while `busy_o` is high neither restarts nor extends the pass and sets the sticky `ovr_o` from the next cycle.
- R12: An entry with gain code above 3, a single-ended channel above 24, or a differential channel outside 0 to 11 and 24 produces no conversion or sample, sets the sticky `err_o` from the next cycle, and is passed in one cycle, still obeying bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cv_mode_i | input | 1 | 1: conversions paced by conversion clock; hold stable during a pass |
| scan_pulse_i | input | 1 | Scan-start pulse |
| conv_pulse_i | input | 1 | Conversion-clock pulse |
| lst_we_i | input | 1 | List write enable |
| lst_addr_i | input | IDX_W | List write entry index |
| lst_data_i | input | 32 | List entry to write |
| adc_done_i | input | 1 | Converter reports result ready |
| mux_pos_o | output | 5 | Positive multiplexer input |
| mux_neg_o | output | 5 | Negative multiplexer input (31 = analog ground) |
| diff_o | output | 1 | Differential wiring selected |
| gain_o | output | 2 | Gain code |
| conv_o | output | 1 | Convert strobe |
| ts_req_o | output | 1 | Timestamp insert request |
| smp_valid_o | output | 1 | Sample strobe |
| smp_idx_o | output | IDX_W | List index of the sample |
| smp_chan_o | output | 8 | Channel number of the sample |
| busy_o | output | 1 | Pass in progress |
| ovr_o | output | 1 | Sticky scan overrun |
| err_o | output | 1 | Sticky bad entry |

## Verification
The collision that matters is a scan pulse landing in the very cycle of the final sample strobe: completion and overrun detection meet there, and a weak design either restarts the pass or misses the flag. The bench places a scan pulse exactly on the predicted last sample cycle and expects `ovr_o` to rise the next cycle with `busy_o` dropping and no new conversion. A second overlap, a converter completion arriving while the sequencer is still settling or waiting for a conversion-clock pulse, is driven on purpose and must leave every strobe schedule unchanged.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef struct packed {
    logic       nxt;
    logic [9:0] rsv_hi;
    logic       ts;
    logic       slow;
    logic [2:0] rsv_mid;
    logic       diff;
    logic [2:0] rsv_lo;
    logic [3:0] gain;
    logic [7:0] chan;
  } cl_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SETTLE, ST_WCV, ST_CONV, ST_WDONE, ST_TS, ST_SMP
  } seq_st_e;

  localparam int unsigned SETTLE_US [4] = '{10, 15, 25, 50};
  localparam int unsigned US_HZ         = 1_000_000;
  localparam logic [7:0]  CH_TC         = 8'd24;
  localparam logic [7:0]  DIFF_PAIRS    = 8'd12;
  localparam logic [3:0]  GAIN_MAX      = 4'd3;
  localparam logic [4:0]  MUX_TC_NEG    = 5'd25;
  localparam logic [4:0]  MUX_GND       = 5'd31;

endpackage

// File: rtl/cl_list_mem.sv
module cl_list_mem #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))           mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cl_entry_dec.sv
module cl_entry_dec
  import scan_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          CNT_W  = 13
) (
  input  cl_entry_t        entry_i,
  output logic             ok_o,
  output logic [4:0]       mux_pos_o,
  output logic [4:0]       mux_neg_o,
  output logic             diff_o,
  output logic [1:0]       gain_o,
  output logic [CNT_W-1:0] settle_o
);
  logic [CNT_W-1:0] cyc_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign cyc_tab[g] = CNT_W'((64'(SETTLE_US[g]) * 64'(CLK_HZ)) / 64'(US_HZ));
  end

  logic is_tc, chan_ok, gain_ok;

  always_comb begin
    is_tc   = (entry_i.chan == CH_TC);
    gain_ok = (entry_i.gain <= GAIN_MAX);
    if (entry_i.diff) chan_ok = (entry_i.chan < DIFF_PAIRS) || is_tc;
    else              chan_ok = (entry_i.chan <= CH_TC);
    ok_o   = gain_ok && chan_ok;
    diff_o = entry_i.diff;
    gain_o = entry_i.gain[1:0];

    mux_pos_o = is_tc ? CH_TC[4:0] : entry_i.chan[4:0];
    if (!entry_i.diff) mux_neg_o = MUX_GND;
    else if (is_tc)    mux_neg_o = MUX_TC_NEG;
    else               mux_neg_o = entry_i.chan[4:0] + DIFF_PAIRS[4:0];

    settle_o = entry_i.slow ? (cyc_tab[entry_i.gain[1:0]] << 1)
                            :  cyc_tab[entry_i.gain[1:0]];
  end
endmodule

// File: rtl/cl_settle_tmr.sv
module cl_settle_tmr #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  // len_i counts cycles spent waiting, so preload one less
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= len_i - 1'b1;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter  int unsigned     CLK_HZ     = 50_000_000,
  parameter  int unsigned     LIST_DEPTH = 32,
  localparam int              IDX_W      = $clog2(LIST_DEPTH),
  localparam longint unsigned MAX_SET    = (64'(2 * SETTLE_US[3]) * 64'(CLK_HZ)) / 64'(US_HZ),
  localparam int              CNT_W      = $clog2(MAX_SET + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cv_mode_i,
  input  logic             scan_pulse_i,
  input  logic             conv_pulse_i,
  input  logic             lst_we_i,
  input  logic [IDX_W-1:0] lst_addr_i,
  input  logic [31:0]      lst_data_i,
  input  logic             adc_done_i,
  output logic [4:0]       mux_pos_o,
  output logic [4:0]       mux_neg_o,
  output logic             diff_o,
  output logic [1:0]       gain_o,
  output logic             conv_o,
  output logic             ts_req_o,
  output logic             smp_valid_o,
  output logic [IDX_W-1:0] smp_idx_o,
  output logic [7:0]       smp_chan_o,
  output logic             busy_o,
  output logic             ovr_o,
  output logic             err_o
);
  seq_st_e          state_q;
  logic [IDX_W-1:0] idx_q;
  cl_entry_t        cur_q;
  logic             ovr_q, err_q;

  logic [IDX_W-1:0] rd_addr;
  logic [31:0]      rd_data;
  logic             ent_ok;
  logic [CNT_W-1:0] settle_len;
  logic             tmr_zero, tmr_load;
  logic             go_next;

  assign rd_addr = (state_q == ST_IDLE) ? '0 : idx_q + 1'b1;
  assign go_next = cur_q.nxt && (idx_q != IDX_W'(LIST_DEPTH - 1));
  assign tmr_load = (state_q == ST_CHECK) && ent_ok && !cv_mode_i;

  cl_list_mem #(.DEPTH(LIST_DEPTH), .AW(IDX_W), .DW(32)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lst_we_i),
    .waddr_i (lst_addr_i),
    .wdata_i (lst_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  cl_entry_dec #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dec (
    .entry_i   (cur_q),
    .ok_o      (ent_ok),
    .mux_pos_o (mux_pos_o),
    .mux_neg_o (mux_neg_o),
    .diff_o    (diff_o),
    .gain_o    (gain_o),
    .settle_o  (settle_len)
  );

  cl_settle_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (settle_len),
    .run_i  (state_q == ST_SETTLE),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      ovr_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (scan_pulse_i && state_q != ST_IDLE) ovr_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (scan_pulse_i) begin
          state_q <= ST_CHECK;
          idx_q   <= '0;
          cur_q   <= cl_entry_t'(rd_data);
        end
        ST_CHECK: begin
          if (!ent_ok) begin
            err_q <= 1'b1;
            if (go_next) begin
              idx_q <= idx_q + 1'b1;
              cur_q <= cl_entry_t'(rd_data);
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            state_q <= cv_mode_i ? ST_WCV : ST_SETTLE;
          end
        end
        ST_SETTLE: if (tmr_zero)     state_q <= ST_CONV;
        ST_WCV:    if (conv_pulse_i) state_q <= ST_CONV;
        ST_CONV:                     state_q <= ST_WDONE;
        ST_WDONE:  if (adc_done_i)   state_q <= cur_q.ts ? ST_TS : ST_SMP;
        ST_TS:                       state_q <= ST_SMP;
        ST_SMP: begin
          if (go_next) begin
            state_q <= ST_CHECK;
            idx_q   <= idx_q + 1'b1;
            cur_q   <= cl_entry_t'(rd_data);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o      = (state_q == ST_CONV);
  assign ts_req_o    = (state_q == ST_TS);
  assign smp_valid_o = (state_q == ST_SMP);
  assign smp_idx_o   = idx_q;
  assign smp_chan_o  = cur_q.chan;
  assign busy_o      = (state_q != ST_IDLE);
  assign ovr_o       = ovr_q;
  assign err_o       = err_q;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cv_mode_i,
  input logic             scan_pulse_i,
  input logic             conv_pulse_i,
  input logic             lst_we_i,
  input logic [IDX_W-1:0] lst_addr_i,
  input logic [31:0]      lst_data_i,
  input logic             adc_done_i,
  input logic [4:0]       mux_pos_o,
  input logic [4:0]       mux_neg_o,
  input logic             diff_o,
  input logic [1:0]       gain_o,
  input logic             conv_o,
  input logic             ts_req_o,
  input logic             smp_valid_o,
  input logic [IDX_W-1:0] smp_idx_o,
  input logic [7:0]       smp_chan_o,
  input logic             busy_o,
  input logic             ovr_o,
  input logic             err_o
);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(conv_o || ts_req_o || smp_valid_o));

  a_r3_scan_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && scan_pulse_i) |=> busy_o);

  a_r4_conv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);

  a_r6_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> ($stable(mux_pos_o) && $stable(mux_neg_o) && $stable(gain_o)));

  a_r8_smp_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !$past(ts_req_o)) |-> $past(adc_done_i));

  a_r9_ts_then_smp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_req_o |=> smp_valid_o);

  a_r10_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_o, ts_req_o, smp_valid_o}));

  a_r11_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && scan_pulse_i) |=> ovr_o);

  a_r11_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);

  a_r12_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind scan_seq scan_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/scan_seq_tb.sv
module scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 1_000_000;
  localparam int ADC_LAT    = 2;
  localparam int NONE       = 1 << 30;

  logic        clk, rst_ni, cv_mode, scan_pulse, conv_pulse, lst_we, adc_done;
  logic [4:0]  lst_addr, mux_pos, mux_neg, smp_idx;
  logic [31:0] lst_data;
  logic        diff, conv, ts_req, smp_valid, busy, ovr, err;
  logic [1:0]  gain;
  logic [7:0]  smp_chan;

  scan_seq #(.CLK_HZ(HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cv_mode_i(cv_mode), .scan_pulse_i(scan_pulse),
    .conv_pulse_i(conv_pulse), .lst_we_i(lst_we), .lst_addr_i(lst_addr),
    .lst_data_i(lst_data), .adc_done_i(adc_done), .mux_pos_o(mux_pos),
    .mux_neg_o(mux_neg), .diff_o(diff), .gain_o(gain), .conv_o(conv),
    .ts_req_o(ts_req), .smp_valid_o(smp_valid), .smp_idx_o(smp_idx),
    .smp_chan_o(smp_chan), .busy_o(busy), .ovr_o(ovr), .err_o(err)
  );

  int    cyc = 0, total = 0, bad = 0;
  bit    chk_en = 0;
  string cur_req = "R2";
  int    err_from = NONE, ovr_from = NONE;
  logic [31:0] sh [32];

  bit exp_conv[int], exp_ts[int], exp_busy[int];
  bit scan_at[int], cvp_at[int], done_at[int];
  int exp_sidx[int], exp_schan[int], exp_pos[int], exp_neg[int], exp_dif[int], exp_gn[int];

  initial begin clk = 0; forever #(CLK_PERIOD / 2) clk = ~clk; end
  initial forever @(posedge clk) cyc++;

  // stimulus driver and converter model
  initial begin
    scan_pulse = 0; conv_pulse = 0; adc_done = 0;
    forever @(negedge clk) begin
      if (conv === 1'b1) done_at[cyc + ADC_LAT] = 1;
      scan_pulse = scan_at.exists(cyc);
      conv_pulse = cvp_at.exists(cyc);
      adc_done   = done_at.exists(cyc);
    end
  end

  task automatic chk(string tag, string sig, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s cyc=%0d got=%0d exp=%0d", tag, sig, cyc, got, expv);
    end
  endtask

  // per-cycle comparison against the schedule
  initial forever @(negedge clk) if (chk_en) begin
    chk(cur_req, "conv_o", int'(conv), int'(exp_conv.exists(cyc)));
    chk(cur_req, "ts_req_o", int'(ts_req), int'(exp_ts.exists(cyc)));
    chk(cur_req, "smp_valid_o", int'(smp_valid), int'(exp_sidx.exists(cyc)));
    chk(cur_req, "busy_o", int'(busy), int'(exp_busy.exists(cyc)));
    chk("R12", "err_o", int'(err), int'(cyc >= err_from));
    chk("R11", "ovr_o", int'(ovr), int'(cyc >= ovr_from));
    if (exp_sidx.exists(cyc)) begin
      chk("R8", "smp_idx_o", int'(smp_idx), exp_sidx[cyc]);
      chk("R8", "smp_chan_o", int'(smp_chan), exp_schan[cyc]);
    end
    if (exp_pos.exists(cyc)) begin
      chk("R6", "mux_pos_o", int'(mux_pos), exp_pos[cyc]);
      chk("R6", "mux_neg_o", int'(mux_neg), exp_neg[cyc]);
      chk("R6", "diff_o", int'(diff), exp_dif[cyc]);
      chk("R6", "gain_o", int'(gain), exp_gn[cyc]);
    end
  end

  function automatic logic [31:0] mk(bit nx, bit ts, bit sl, bit df, int gn, int ch);
    return {nx, 10'b0, ts, sl, 3'b0, df, 3'b0, 4'(gn), 8'(ch)};
  endfunction

  function automatic bit ent_ok(logic [31:0] e);
    int gn = int'(e[11:8]);
    int ch = int'(e[7:0]);
    if (gn > 3) return 0;
    if (e[15]) return (ch < 12) || (ch == 24);
    return ch <= 24;
  endfunction

  function automatic int settle_n(logic [31:0] e);
    int us;
    case (e[9:8])
      2'd0: us = 10;
      2'd1: us = 15;
      2'd2: us = 25;
      default: us = 50;
    endcase
    return (us * (HZ / 1_000_000)) * (e[19] ? 2 : 1);
  endfunction

  // builds the expected strobe schedule of one pass; returns its last busy cycle
  task automatic plan(int t, bit cvm, int per, output int last);
    int k, idx, c, p, s, ch;
    logic [31:0] e;
    k = t + 1; idx = 0;
    forever begin
      e = sh[idx];
      if (!ent_ok(e)) begin
        if (err_from > k + 1) err_from = k + 1;
        s = k;
      end else begin
        if (cvm) begin
          p = t + 1;
          while (p < k + 1) p += per;
          c = p + 1;
        end else begin
          c = k + settle_n(e) + 1;
        end
        ch = int'(e[7:0]);
        exp_conv[c] = 1;
        exp_pos[c]  = ch;
        exp_neg[c]  = !e[15] ? 31 : (ch == 24 ? 25 : ch + 12);
        exp_dif[c]  = int'(e[15]);
        exp_gn[c]   = int'(e[9:8]);
        if (e[20]) begin
          exp_ts[c + ADC_LAT + 1] = 1;
          s = c + ADC_LAT + 2;
        end else begin
          s = c + ADC_LAT + 1;
        end
        exp_sidx[s]  = idx;
        exp_schan[s] = ch;
      end
      for (int j = k; j <= s; j++) exp_busy[j] = 1;
      if (e[31] && idx < 31) begin
        idx++;
        k = s + 1;
      end else begin
        break;
      end
    end
    last = s;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    lst_we = 1; lst_addr = 5'(a); lst_data = d; sh[a] = d;
    @(negedge clk);
    lst_we = 0;
  endtask

  task automatic run(string tag, bit cvm, int per, bit stray_cv, bit stray_done, bit ovr_end);
    int t, last;
    cur_req = tag;
    @(negedge clk);
    cv_mode = cvm;
    t = cyc + 2;
    if (cvm || stray_cv)
      for (int m = 0; m < 48; m++) cvp_at[t + 1 + m * per] = 1;
    if (stray_done) begin
      done_at[t - 1] = 1;
      done_at[t + 4] = 1;
    end
    scan_at[t] = 1;
    plan(t, cvm, per, last);
    if (ovr_end) begin
      scan_at[last] = 1;
      if (ovr_from > last + 1) ovr_from = last + 1;
    end
    while (cyc < last + 4) @(negedge clk);
  endtask

  initial begin
    rst_ni = 0; cv_mode = 0; lst_we = 0; lst_addr = 0; lst_data = 0;
    for (int i = 0; i < 32; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R2: reset state
    chk("R2", "busy_o", int'(busy), 0);
    chk("R2", "conv_o", int'(conv), 0);
    chk("R2", "smp_valid_o", int'(smp_valid), 0);
    chk("R2", "ts_req_o", int'(ts_req), 0);
    chk("R2", "ovr_o", int'(ovr), 0);
    chk("R2", "err_o", int'(err), 0);
    chk_en = 1;

    // R1 R3 R4: four gains, scan-clock mode, stray conversion pulses and done
    wr(0, mk(1, 0, 0, 0, 0, 3));
    wr(1, mk(1, 0, 0, 0, 1, 7));
    wr(2, mk(1, 0, 0, 0, 2, 20));
    wr(3, mk(0, 0, 0, 0, 3, 24));
    run("R1/R3/R4", 0, 5, 1, 1, 0);

    // R5: doubled settling
    wr(0, mk(1, 0, 1, 0, 0, 1));
    wr(1, mk(0, 0, 1, 0, 3, 2));
    run("R5", 0, 5, 0, 0, 0);

    // R6: differential pairs and compensation input
    wr(0, mk(1, 0, 0, 1, 1, 5));
    wr(1, mk(1, 0, 0, 1, 0, 24));
    wr(2, mk(0, 0, 0, 1, 2, 11));
    run("R6", 0, 5, 0, 0, 0);

    // R7 R8: conversion-clock pacing, early pulse and stray done ignored
    run("R7/R8", 1, 7, 0, 1, 0);

    // R9: timestamp requests
    wr(0, mk(1, 1, 0, 0, 0, 0));
    wr(1, mk(0, 1, 0, 0, 0, 2));
    run("R9", 0, 5, 0, 0, 0);

    // R12: skipped entries
    wr(0, mk(1, 0, 0, 0, 5, 4));
    wr(1, mk(1, 0, 0, 1, 0, 13));
    wr(2, mk(1, 0, 0, 0, 0, 30));
    wr(3, mk(0, 0, 0, 0, 0, 4));
    run("R12", 0, 5, 0, 0, 0);

    // R11: scan pulse on the final sample strobe cycle
    wr(0, mk(0, 0, 0, 0, 0, 9));
    run("R11", 0, 5, 0, 0, 1);

    // R10: full list ends at the last entry even with the follow bit set
    for (int i = 0; i < 32; i++) wr(i, mk(1, 0, 0, 0, 0, i % 24));
    run("R10", 0, 5, 0, 0, 0);

    chk_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule